// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a software-liveness watchdog. A free-running prescaler advances a small timeout counter. If software lets that counter wrap, the block forces a system reset. Software keeps the system alive by writing to one dedicated bus address. That address shares its location with the low byte of the reset vector, so a read of it returns the vector byte and never any watchdog state.

A configuration input chooses which prescaler tap clocks the timeout counter, which gives a long or a short period. A second configuration input switches the watchdog off, and a stop input freezes it.

A timeout starts a two-phase reset. First the external reset line is driven low for a fixed number of cycles. Then the system alone stays in reset for a further fixed number of cycles. A sticky flag records that the watchdog caused the reset, and only power-on reset clears it. Power-on reset arrives as an active-low input and clears all state.

Top module: `cop_watchdog`

## Requirements
- R1: After power-on reset (`por_n` low), `sys_rst` = 0, `rst_pin_n` = 1 and `cop_flag` = 0.
- R2: The phase is the low KEEP_W prescaler bits. It counts the rising edges since `por_n` was released on which `stop_i` = 0, and only power-on reset clears it. With `cfg_short` = 0, a service write on an edge where the phase is L makes `sys_rst` rise exactly 2^(PRE_W+CNT_W) − ((L+1) mod 2^KEEP_W) edges after that service edge.
- R3: With `cfg_short` = 1, the same delay is 2^(SHORT_W+CNT_W) − ((L+1) mod 2^KEEP_W) edges.
- R4: A write strobe (`wr_en` = 1) with `addr` = SERV_ADDR services the watchdog. A write to any other address does not change the timeout.
- R5: `rd_data` equals RST_VEC_LO while `addr` = SERV_ADDR and is 0 for any other address.
- R6: `rst_pin_n` is low for exactly LOW_CYC cycles. This starts in the cycle in which `sys_rst` rises.
- R7: `sys_rst` stays high for exactly LOW_CYC + HOLD_CYC cycles. Let V be the phase after the edge on which `sys_rst` falls. Without service, the next timeout then follows 2^(T) − V edges later, where T is the rate exponent from R2/R3.
- R8: `cop_flag` is set by a timeout and stays set until power-on reset.
- R9: While `cfg_disable` = 1 no reset is issued and the timeout counter is held clear. After release on an edge with phase L, the timeout follows 2^(T) − L edges later.
- R10: While `stop_i` = 1 the prescaler, phase and counter hold, so a timeout is delayed by exactly the number of stopped edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_short | input | 1 | 1 selects the short timeout tap |
| cfg_disable | input | 1 | 1 turns the watchdog off |
| stop_i | input | 1 | 1 freezes prescaler and counter |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| rd_data | output | 8 | Read data for the service address |
| rst_pin_n | output | 1 | External reset drive, active low |
| sys_rst | output | 1 | Internal system reset, active high |
| cop_flag | output | 1 | Sticky watchdog-reset status |

## Verification
The assertions assume a few things about the inputs. `por_n` is the only path back to the idle state. The configuration inputs move only at cycle boundaries, and nobody depends on stop being applied during a reset sequence. The stimulus drives every input on the falling edge. It changes `cfg_short` and `cfg_disable` only while the watchdog is serviced or disabled, and it raises `stop_i` only outside a reset sequence. It also keeps its own phase counter so that it can aim service writes at every phase value.

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int PRE_W    = 12,
  parameter int CNT_W    = 6,
  parameter int SHORT_W  = 7,
  parameter int KEEP_W   = 4,
  parameter int LOW_CYC  = 32,
  parameter int HOLD_CYC = 32,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SERV_ADDR  = '1,
  parameter logic [7:0]        RST_VEC_LO = 8'h00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_short,
  input  logic              cfg_disable,
  input  logic              stop_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_data,
  output logic              rst_pin_n,
  output logic              sys_rst,
  output logic              cop_flag
);
  localparam int HI_W  = PRE_W - KEEP_W;
  localparam int SEQ_W = $clog2(LOW_CYC + HOLD_CYC);
  localparam logic [SEQ_W-1:0] LOW_END = SEQ_W'(LOW_CYC);
  localparam logic [SEQ_W-1:0] SEQ_END = SEQ_W'(LOW_CYC + HOLD_CYC - 1);

  logic [KEEP_W-1:0] pre_lo;
  logic [HI_W-1:0]   pre_hi;
  logic [CNT_W-1:0]  cnt;
  logic [SEQ_W-1:0]  seq_cnt;
  logic              seq_on;

  wire [PRE_W-1:0] pre  = {pre_hi, pre_lo};
  wire             hit  = (addr == SERV_ADDR);
  wire             svc  = wr_en && hit;
  wire             tick = cfg_short ? &pre[SHORT_W-1:0] : &pre;
  wire             ovf  = tick && (&cnt);

  assign rd_data   = hit ? RST_VEC_LO : 8'h00;
  assign sys_rst   = seq_on;
  assign rst_pin_n = !(seq_on && seq_cnt < LOW_END);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_lo   <= '0;
      pre_hi   <= '0;
      cnt      <= '0;
      seq_on   <= 1'b0;
      seq_cnt  <= '0;
      cop_flag <= 1'b0;
    end else begin
      if (!stop_i) pre_lo <= pre_lo + KEEP_W'(1);
      if (seq_on) begin
        pre_hi  <= '0;
        cnt     <= '0;
        seq_cnt <= seq_cnt + SEQ_W'(1);
        if (seq_cnt == SEQ_END) begin
          seq_on  <= 1'b0;
          seq_cnt <= '0;
        end
      end else if (cfg_disable || svc) begin
        pre_hi <= '0;
        cnt    <= '0;
      end else if (!stop_i) begin
        pre_hi <= pre_hi + HI_W'(&pre_lo);
        cnt    <= cnt + CNT_W'(tick);
        if (ovf) begin
          seq_on   <= 1'b1;
          seq_cnt  <= '0;
          cop_flag <= 1'b1;
        end
      end
    end
  end

  // R4
  svc_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    svc |=> cnt == '0);
  // R6
  pin_low_at_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> !rst_pin_n);
  // R7
  pin_release_in_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_pin_n) |-> sys_rst);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    cop_flag |=> cop_flag);
  // R9
  no_reset_when_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_disable && !sys_rst |=> !sys_rst && cnt == '0);
  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    stop_i && !seq_on |=> $stable(cnt) && $stable(pre_hi) && $stable(pre_lo));
endmodule

// File: tb/test_cop_watchdog.sv
module test_cop_watchdog;
  localparam int PRE_W = 8, CNT_W = 4, SHORT_W = 5, KEEP_W = 4;
  localparam int LOW_CYC = 32, HOLD_CYC = 32;
  localparam logic [15:0] SERV = 16'hFFFF;
  localparam logic [7:0]  VEC  = 8'hA5;
  localparam int LONG_T  = 1 << (PRE_W + CNT_W);
  localparam int SHORT_T = 1 << (SHORT_W + CNT_W);

  logic clk = 0, por_n = 0, cfg_short = 1, cfg_disable = 0, stop_i = 0, wr_en = 0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] rd_data;
  logic rst_pin_n, sys_rst, cop_flag;
  logic [3:0] ph;
  int checks = 0, fails = 0;

  cop_watchdog #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W), .KEEP_W(KEEP_W),
    .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC), .ADDR_W(16), .SERV_ADDR(SERV),
    .RST_VEC_LO(VEC)) i_cop_watchdog (
    .clk(clk), .por_n(por_n), .cfg_short(cfg_short), .cfg_disable(cfg_disable),
    .stop_i(stop_i), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
    .rst_pin_n(rst_pin_n), .sys_rst(sys_rst), .cop_flag(cop_flag));

  always #2 clk = ~clk;

  always @(posedge clk or negedge por_n)
    if (!por_n) ph <= '0;
    else if (!stop_i) ph <= ph + 4'd1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic service(input logic [15:0] a, output int l);
    @(negedge clk);
    l = ph; wr_en = 1; addr = a;
    @(posedge clk); #1 wr_en = 0; addr = 16'h0000;
  endtask

  task automatic measure(inout int n);
    do begin @(posedge clk); n++; #1; end while (!sys_rst && n < 20000);
  endtask

  task automatic run_seq(output int lowc, output int highc, output int v);
    lowc = rst_pin_n ? 0 : 1; highc = 1;
    forever begin
      @(posedge clk); #1;
      if (!sys_rst) break;
      highc++;
      if (!rst_pin_n) lowc++;
    end
    v = ph;
  endtask

  task automatic wait_phase(input int t);
    while (ph != t[3:0]) @(negedge clk);
  endtask

  task automatic timed_case(input string req, input int per, input int t);
    int l, n, lo, hi, v;
    #0;
    wait_phase(t);
    service(SERV, l);
    n = 0; measure(n);
    chk(req, n, per - ((l + 1) % 16));
    run_seq(lo, hi, v);
    chk("R6", lo, LOW_CYC);
    chk("R7", hi, LOW_CYC + HOLD_CYC);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int l, n, lo, hi, v, seen;
    #7 chk("R1 sys_rst", sys_rst, 0);
    chk("R1 rst_pin_n", rst_pin_n, 1);
    chk("R1 cop_flag", cop_flag, 0);
    @(negedge clk) por_n = 1;

    // R5 read path
    @(negedge clk) addr = SERV; #1 chk("R5 vec", rd_data, VEC);
    addr = 16'h1234; #1 chk("R5 other", rd_data, 0);
    addr = 16'h0000;

    // R3 short rate, every phase
    cfg_short = 1;
    for (int t = 0; t < 16; t++) timed_case("R3", SHORT_T, t);
    chk("R8 set", cop_flag, 1);

    // R7 free-running timeout after sequence end
    n = 0; measure(n);
    run_seq(lo, hi, v);
    service(SERV, l);
    n = 0; measure(n);
    chk("R3", n, SHORT_T - ((l + 1) % 16));
    run_seq(lo, hi, v);
    n = 0; measure(n);
    chk("R7 restart", n, SHORT_T - v);
    run_seq(lo, hi, v);

    // R2 long rate, selected phases
    service(SERV, l);
    @(negedge clk) cfg_short = 0;
    for (int t = 0; t < 16; t += 5) timed_case("R2", LONG_T, t);

    // R4 other address does not service
    cfg_short = 1;
    service(SERV, l);
    repeat (200) @(posedge clk);
    service(16'hFFFE, v);
    n = 201; measure(n);
    chk("R4 other addr", n, SHORT_T - ((l + 1) % 16));
    run_seq(lo, hi, v);

    // R4 late service restarts timeout
    service(SERV, l);
    repeat (300) @(posedge clk);
    service(SERV, l);
    n = 0; measure(n);
    chk("R4 restart", n, SHORT_T - ((l + 1) % 16));
    run_seq(lo, hi, v);

    // R10 stop
    service(SERV, l);
    n = 0;
    repeat (100) begin @(posedge clk); n++; end
    @(negedge clk) stop_i = 1;
    seen = 0;
    repeat (300) begin @(posedge clk); n++; #1 if (sys_rst) seen = 1; end
    @(negedge clk) stop_i = 0;
    chk("R10 no reset while stopped", seen, 0);
    measure(n);
    chk("R10 delay", n, SHORT_T - ((l + 1) % 16) + 300);
    run_seq(lo, hi, v);

    // R9 disable
    @(negedge clk) cfg_disable = 1;
    seen = 0;
    repeat (1500) begin @(posedge clk); #1 if (sys_rst) seen = 1; end
    chk("R9 no reset", seen, 0);
    @(negedge clk) cfg_disable = 0; l = ph;
    n = 0; measure(n);
    chk("R9 cleared counter", n, SHORT_T - l);
    run_seq(lo, hi, v);
    chk("R8 held", cop_flag, 1);

    // R8/R1 power-on clears
    @(negedge clk) por_n = 0;
    #1 chk("R8 por clear", cop_flag, 0);
    chk("R1 pin", rst_pin_n, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule